// File: doc/BRIEF.md
# I2C Master Command-Word Sequencer

This block is the control core of an I2C master that is driven entirely by a stream of command words. Each word holds one data byte and two flags, one asking for a START and one asking for a STOP. The block pops words from a show-ahead transmit queue and turns them into bus conditions on open-drain SCL and SDA. In a read, it places each received byte into a receive queue. Every SCL period takes four ticks of an external clock divider.

An address byte is the 7-bit slave address shifted up by one bit, with bit 0 selecting the direction. After a read address, the next word gives the number of bytes to receive. The master acknowledges every byte except the last, refuses the last one, and then ends the transfer.

The block watches the bus lines and reports when the bus is busy. It also raises a one-cycle event when the bus becomes free. A refused byte and a lost arbitration are both reported as sticky flags, and either one makes the block discard the rest of the current command.

Top module: `i2c_cmd_seq`

## Requirements
- R1: A command word is `{stop, start, byte}`: bits 7..0 hold the byte, bit 8 is the start flag and bit 9 is the stop flag. `cmd_pop` is a single-cycle pop and is raised only while `cmd_valid` is high. The outputs `scl_drv_low` and `sda_drv_low` pull a line low when they are 1 and release it when they are 0.
- R2: A word with the start flag set produces a START before its byte is sent. If the bus is already owned, this is a repeated START, and the bus is not freed in between.
- R3: Bytes are sent MSB first. The slave's acknowledge is sampled in the ninth SCL clock of each byte.
- R4: A word with the stop flag ends with a STOP after its acknowledge. `xfer_done` then pulses once, with both lines released.
- R5: A word with both flags set and a write address (bit 0 = 0) sends START, the address and STOP, and nothing else.
- R6: After a read address (bit 0 = 1), the low 8 bits of the next word give a byte count N. The master receives N bytes MSB first and pushes each byte through `rx_push`/`rx_byte`. It ACKs (SDA low) every byte but the last, NACKs (SDA released) the last, and then issues STOP, because that word carries the stop flag.
- R7: If the slave NACKs an address or data byte, `tx_error` is set and a STOP follows with no `xfer_done`. Queued words without the start flag are then popped and dropped. `tx_error` stays set until the next start word is accepted.
- R8: If SDA reads low while the master is releasing it for a 1 bit, `arb_lost` is set, both drive outputs are released, and queued words without the start flag are dropped. `arb_lost` clears when the next start word is accepted.
- R9: Each SCL high time lasts two divider ticks and each SCL period lasts four. During a bit, SDA changes only while SCL is low.
- R10: `bus_busy` rises when a START is seen on the lines and falls when a STOP is seen. `bus_free_evt` pulses for one cycle as the bus becomes free.
- R11: After reset, both lines are released and `bus_busy`, `arb_lost`, `tx_error`, `xfer_done` and `rx_push` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Divider tick, one quarter of an SCL period |
| cmd_valid | input | 1 | Transmit queue holds a word |
| cmd_word | input | 10 | Head word of the transmit queue |
| cmd_pop | output | 1 | Removes the head word |
| scl_in | input | 1 | SCL as seen on the bus |
| sda_in | input | 1 | SDA as seen on the bus |
| scl_drv_low | output | 1 | Pull SCL low |
| sda_drv_low | output | 1 | Pull SDA low |
| rx_push | output | 1 | Received byte valid |
| rx_byte | output | 8 | Received byte |
| bus_busy | output | 1 | Bus is between a START and a STOP |
| bus_free_evt | output | 1 | One-cycle pulse when the bus becomes free |
| arb_lost | output | 1 | Sticky arbitration-lost flag |
| tx_error | output | 1 | Sticky NACK flag |
| xfer_done | output | 1 | One-cycle pulse after a normal STOP |

## Verification
The bench builds the block with its defaults: 8-bit bytes and a two-stage line synchronizer. With the divider tick set every four clocks, a full bit period is 16 clocks, which keeps the synchronizer delay inside one tick, so acknowledge sampling and arbitration are checked with realistic line latency. A modelled slave and a second driver on SDA bring within reach the following cases: refused addresses, the last-byte NACK of a read, a repeated START between a write and a read, and a lost arbitration followed by a queue flush.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WBIT  = 2'd2,
    OP_RBIT  = 2'd3
  } bus_op_e;

  typedef enum logic [2:0] {
    S_FETCH = 3'd0,
    S_START = 3'd1,
    S_WBIT  = 3'd2,
    S_WACK  = 3'd3,
    S_RBIT  = 3'd4,
    S_RACK  = 3'd5,
    S_STOP  = 3'd6,
    S_FLUSH = 3'd7
  } seq_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lines_in,
  output logic [LINES-1:0] lines_out
);

  logic [LINES-1:0] stage_q [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[g] <= '1;
        end else if (g == 0) begin
          stage_q[g] <= lines_in;
        end else begin
          stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign lines_out = stage_q[STAGES-1];

endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic busy,
  output logic free_evt
);

  logic scl_p_q, sda_p_q, busy_q, free_q;
  logic busy_n, free_n, seen_start, seen_stop;

  always_comb begin
    seen_start = scl_s && scl_p_q && sda_p_q && !sda_s;
    seen_stop  = scl_s && scl_p_q && !sda_p_q && sda_s;
    busy_n     = busy_q;
    free_n     = 1'b0;
    if (seen_start) begin
      busy_n = 1'b1;
    end else if (seen_stop) begin
      busy_n = 1'b0;
      free_n = busy_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p_q <= 1'b1;
      sda_p_q <= 1'b1;
      busy_q  <= 1'b0;
      free_q  <= 1'b0;
    end else begin
      scl_p_q <= scl_s;
      sda_p_q <= sda_s;
      busy_q  <= busy_n;
      free_q  <= free_n;
    end
  end

  assign busy     = busy_q;
  assign free_evt = free_q;

  AST_FREE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    free_q |-> !busy_q); // R10

endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    req,
  input  bus_op_e op,
  input  logic    wbit,
  input  logic    sda_s,
  output logic    done,
  output logic    rbit,
  output logic    arb,
  output logic    scl_low,
  output logic    sda_low
);

  logic       busy_q, busy_n;
  logic [1:0] ph_q, ph_n;
  bus_op_e    op_q, op_n;
  logic       wbit_q, wbit_n;
  logic       scl_q, scl_n, sda_q, sda_n;
  logic       rbit_q, rbit_n, done_q, done_n, arb_q, arb_n;
  logic       is_bit;

  assign is_bit = (op_q == OP_WBIT) || (op_q == OP_RBIT);

  always_comb begin
    busy_n = busy_q;
    ph_n   = ph_q;
    op_n   = op_q;
    wbit_n = wbit_q;
    scl_n  = scl_q;
    sda_n  = sda_q;
    rbit_n = rbit_q;
    done_n = 1'b0;
    arb_n  = 1'b0;
    if (!busy_q) begin
      if (req) begin
        busy_n = 1'b1;
        ph_n   = 2'd0;
        op_n   = op;
        wbit_n = wbit;
      end
    end else if (tick) begin
      ph_n = ph_q + 2'd1;
      unique case (op_q)
        OP_START: begin
          unique case (ph_q)
            2'd0: sda_n = 1'b0;
            2'd1: begin scl_n = 1'b0; sda_n = 1'b0; end
            2'd2: sda_n = 1'b1;
            default: scl_n = 1'b1;
          endcase
        end
        OP_STOP: begin
          unique case (ph_q)
            2'd0: begin scl_n = 1'b1; sda_n = 1'b1; end
            2'd1: scl_n = 1'b0;
            2'd2: sda_n = 1'b0;
            default: ;
          endcase
        end
        default: begin
          unique case (ph_q)
            2'd0: begin
              scl_n = 1'b1;
              sda_n = (op_q == OP_WBIT) ? !wbit_q : 1'b0;
            end
            2'd1: scl_n = 1'b0;
            2'd2: rbit_n = sda_s;
            default: scl_n = 1'b1;
          endcase
        end
      endcase
      if (ph_q == 2'd3) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end else if (ph_q == 2'd2 && op_q == OP_WBIT && wbit_q && !sda_s) begin
        busy_n = 1'b0;
        done_n = 1'b1;
        arb_n  = 1'b1;
        scl_n  = 1'b0;
        sda_n  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= 2'd0;
      op_q   <= OP_START;
      wbit_q <= 1'b0;
      scl_q  <= 1'b0;
      sda_q  <= 1'b0;
      rbit_q <= 1'b0;
      done_q <= 1'b0;
      arb_q  <= 1'b0;
    end else begin
      busy_q <= busy_n;
      ph_q   <= ph_n;
      op_q   <= op_n;
      wbit_q <= wbit_n;
      scl_q  <= scl_n;
      sda_q  <= sda_n;
      rbit_q <= rbit_n;
      done_q <= done_n;
      arb_q  <= arb_n;
    end
  end

  assign done    = done_q;
  assign rbit    = rbit_q;
  assign arb     = arb_q;
  assign scl_low = scl_q;
  assign sda_low = sda_q;

  AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && is_bit && !scl_q && !$past(scl_q)) |-> $stable(sda_q)); // R9
  AST_ARB_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    arb_q |-> (!scl_q && !sda_q)); // R8
  AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && tick && ph_q == 2'd3) |=> !busy_q); // R9

endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2c_seq_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int WORD_W     = BYTE_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cmd_valid,
  input  logic [WORD_W-1:0] cmd_word,
  output logic              cmd_pop,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_drv_low,
  output logic              sda_drv_low,
  output logic              rx_push,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              bus_busy,
  output logic              bus_free_evt,
  output logic              arb_lost,
  output logic              tx_error,
  output logic              xfer_done
);

  localparam int BIT_W   = $clog2(BYTE_W);
  localparam int START_B = BYTE_W;
  localparam int STOP_B  = BYTE_W + 1;
  localparam logic [BIT_W-1:0]  TOP_BIT = BIT_W'(BYTE_W - 1);
  localparam logic [BYTE_W-1:0] ONE     = BYTE_W'(1);

  logic [1:0] sync_out;
  logic       scl_s, sda_s;

  i2c_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .lines_in({scl_in, sda_in}), .lines_out(sync_out));
  assign scl_s = sync_out[1];
  assign sda_s = sync_out[0];

  i2c_bus_watch u_watch (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .busy(bus_busy), .free_evt(bus_free_evt));

  logic    eng_req, eng_wbit, eng_done, eng_rbit, eng_arb;
  bus_op_e eng_op;

  i2c_bit_engine u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req(eng_req), .op(eng_op),
    .wbit(eng_wbit), .sda_s(sda_s), .done(eng_done), .rbit(eng_rbit),
    .arb(eng_arb), .scl_low(scl_drv_low), .sda_low(sda_drv_low));

  seq_state_e        st_q, st_n;
  logic              wait_q, wait_n;
  logic [WORD_W-1:0] word_q, word_n;
  logic [BIT_W-1:0]  bitc_q, bitc_n;
  logic [BYTE_W-1:0] cnt_q, cnt_n, sh_q, sh_n, rxb_q, rxb_n;
  logic              rd_q, rd_n, err_q, err_n, arb_q, arb_n;
  logic              done_q, done_n, push_q, push_n, estop_q, estop_n;
  logic              finished;

  assign finished = wait_q && eng_done;

  always_comb begin
    st_n     = st_q;
    wait_n   = wait_q;
    word_n   = word_q;
    bitc_n   = bitc_q;
    cnt_n    = cnt_q;
    sh_n     = sh_q;
    rxb_n    = rxb_q;
    rd_n     = rd_q;
    err_n    = err_q;
    arb_n    = arb_q;
    estop_n  = estop_q;
    done_n   = 1'b0;
    push_n   = 1'b0;
    cmd_pop  = 1'b0;
    eng_req  = 1'b0;
    eng_op   = OP_WBIT;
    eng_wbit = 1'b0;

    if (st_q != S_FETCH && st_q != S_FLUSH && !wait_q) begin
      eng_req = 1'b1;
      wait_n  = 1'b1;
    end
    if (finished) begin
      wait_n = 1'b0;
    end

    unique case (st_q)
      S_FETCH: begin
        if (cmd_valid) begin
          cmd_pop = 1'b1;
          word_n  = cmd_word;
          bitc_n  = TOP_BIT;
          if (cmd_word[START_B]) begin
            err_n = 1'b0;
            arb_n = 1'b0;
            rd_n  = cmd_word[0];
            st_n  = S_START;
          end else if (rd_q) begin
            cnt_n = cmd_word[BYTE_W-1:0];
            if (cmd_word[BYTE_W-1:0] != '0) begin
              st_n = S_RBIT;
            end else if (cmd_word[STOP_B]) begin
              st_n = S_STOP;
            end
          end else begin
            st_n = S_WBIT;
          end
        end
      end
      S_START: begin
        eng_op = OP_START;
        if (finished) st_n = S_WBIT;
      end
      S_WBIT: begin
        eng_op   = OP_WBIT;
        eng_wbit = word_q[bitc_q];
        if (finished) begin
          if (bitc_q == '0) st_n = S_WACK;
          else              bitc_n = bitc_q - 1'b1;
        end
      end
      S_WACK: begin
        eng_op = OP_RBIT;
        if (finished) begin
          if (eng_rbit) begin
            err_n   = 1'b1;
            estop_n = 1'b1;
            st_n    = S_STOP;
          end else if (word_q[STOP_B]) begin
            st_n = S_STOP;
          end else begin
            st_n = S_FETCH;
          end
        end
      end
      S_RBIT: begin
        eng_op = OP_RBIT;
        if (finished) begin
          sh_n = {sh_q[BYTE_W-2:0], eng_rbit};
          if (bitc_q == '0) begin
            rxb_n  = {sh_q[BYTE_W-2:0], eng_rbit};
            push_n = 1'b1;
            st_n   = S_RACK;
          end else begin
            bitc_n = bitc_q - 1'b1;
          end
        end
      end
      S_RACK: begin
        eng_op   = OP_WBIT;
        eng_wbit = (cnt_q == ONE);
        if (finished) begin
          cnt_n  = cnt_q - 1'b1;
          bitc_n = TOP_BIT;
          if (cnt_q != ONE)           st_n = S_RBIT;
          else if (word_q[STOP_B])    st_n = S_STOP;
          else                        st_n = S_FETCH;
        end
      end
      S_STOP: begin
        eng_op = OP_STOP;
        if (finished) begin
          done_n  = !estop_q;
          estop_n = 1'b0;
          st_n    = estop_q ? S_FLUSH : S_FETCH;
        end
      end
      default: begin
        if (cmd_valid && !cmd_word[START_B]) cmd_pop = 1'b1;
        else                                 st_n    = S_FETCH;
      end
    endcase

    if (finished && eng_arb) begin
      arb_n   = 1'b1;
      estop_n = 1'b0;
      push_n  = 1'b0;
      done_n  = 1'b0;
      st_n    = S_FLUSH;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_FETCH;
      wait_q  <= 1'b0;
      word_q  <= '0;
      bitc_q  <= '0;
      cnt_q   <= '0;
      sh_q    <= '0;
      rxb_q   <= '0;
      rd_q    <= 1'b0;
      err_q   <= 1'b0;
      arb_q   <= 1'b0;
      estop_q <= 1'b0;
      done_q  <= 1'b0;
      push_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      wait_q  <= wait_n;
      word_q  <= word_n;
      bitc_q  <= bitc_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      rxb_q   <= rxb_n;
      rd_q    <= rd_n;
      err_q   <= err_n;
      arb_q   <= arb_n;
      estop_q <= estop_n;
      done_q  <= done_n;
      push_q  <= push_n;
    end
  end

  assign rx_push   = push_q;
  assign rx_byte   = rxb_q;
  assign arb_lost  = arb_q;
  assign tx_error  = err_q;
  assign xfer_done = done_q;

  AST_POP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pop |-> cmd_valid); // R1
  AST_DONE_LINES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!scl_drv_low && !sda_drv_low)); // R4
  AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !done_q); // R7
  AST_PUSH_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    push_q |-> rd_q); // R6

endmodule

// File: tb/sim_i2c_cmd_seq.sv
module sim_i2c_cmd_seq;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int WDOG_LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick;
  logic       cmd_valid, cmd_pop;
  logic [9:0] cmd_word;
  logic       scl_drv_low, sda_drv_low, rx_push, bus_busy, bus_free_evt;
  logic       arb_lost, tx_error, xfer_done;
  logic [7:0] rx_byte;
  logic       slv_low = 1'b0;
  logic       ext_low = 1'b0;
  logic       scl_line, sda_line;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_line = !scl_drv_low;
  assign sda_line = !(sda_drv_low || slv_low || ext_low);

  i2c_cmd_seq u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid),
    .cmd_word(cmd_word), .cmd_pop(cmd_pop), .scl_in(scl_line), .sda_in(sda_line),
    .scl_drv_low(scl_drv_low), .sda_drv_low(sda_drv_low), .rx_push(rx_push),
    .rx_byte(rx_byte), .bus_busy(bus_busy), .bus_free_evt(bus_free_evt),
    .arb_lost(arb_lost), .tx_error(tx_error), .xfer_done(xfer_done));

  int div = 0;
  always @(posedge clk) div <= (div == TICK_DIV-1) ? 0 : div + 1;
  assign tick = (div == TICK_DIV-1);

  logic [9:0] fifo [16];
  int wp = 0;
  int rp = 0;
  assign cmd_valid = (wp != rp);
  assign cmd_word  = fifo[rp % 16];
  always @(posedge clk) if (cmd_pop && cmd_valid) rp <= rp + 1;

  int n_done = 0, n_free = 0, n_rx = 0, hrun = 0, last_high = 0, cyc = 0;
  logic [7:0] rxq [16];
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (xfer_done) n_done <= n_done + 1;
    if (bus_free_evt) n_free <= n_free + 1;
    if (rx_push) begin rxq[n_rx % 16] <= rx_byte; n_rx <= n_rx + 1; end
    if (scl_line) hrun <= hrun + 1;
    else begin if (hrun != 0) last_high <= hrun; hrun <= 0; end
  end

  // slave model
  logic       ack_en = 1'b1;
  logic [7:0] txdat [4];
  logic       p_scl = 1'b1, p_sda = 1'b1;
  logic       active = 1'b0, addr_ph = 1'b0, rw = 1'b0, sending = 1'b0;
  logic [7:0] sh = 8'h00;
  int bitn = 0, ti = 0, nlog = 0, nmack = 0;
  logic [7:0] slog [16];
  logic       mack [16];

  always @(scl_line or sda_line) begin
    if (sda_line != p_sda && scl_line && p_scl) begin
      if (!sda_line) begin
        active = 1'b1; bitn = -1; addr_ph = 1'b1; rw = 1'b0; ti = 0;
        sending = 1'b0; slv_low = 1'b0;
      end else begin
        active = 1'b0; slv_low = 1'b0;
      end
    end else if (scl_line != p_scl && active) begin
      if (scl_line) begin
        if (bitn >= 0 && bitn <= 7) begin
          sh = {sh[6:0], sda_line};
          if (bitn == 7) begin
            if (addr_ph) rw = sda_line;
            if (addr_ph || !rw) begin slog[nlog % 16] = sh; nlog = nlog + 1; end
          end
        end else if (bitn == 8 && rw && !addr_ph) begin
          mack[nmack % 16] = sda_line; nmack = nmack + 1;
          if (sda_line) sending = 1'b0; else ti = ti + 1;
        end
      end else begin
        bitn = bitn + 1;
        if (bitn == 8) begin
          slv_low = (!rw || addr_ph) ? ack_en : 1'b0;
        end else if (bitn == 9) begin
          bitn = 0;
          if (addr_ph) begin addr_ph = 1'b0; sending = rw && ack_en; end
          slv_low = (rw && !addr_ph && sending) ? !txdat[ti % 4][7] : 1'b0;
        end else if (bitn >= 1 && bitn <= 7) begin
          if (rw && !addr_ph && sending) slv_low = !txdat[ti % 4][7-bitn];
        end
      end
    end
    p_scl = scl_line;
    p_sda = sda_line;
  end

  int n_chk = 0, n_fail = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [9:0] w);
    fifo[wp % 16] = w;
    wp = wp + 1;
  endtask

  task automatic wait_idle();
    wait (bus_busy === 1'b1);
    wait (bus_busy === 1'b0);
    repeat (40) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R11 scl released", scl_drv_low, 0);
    check("R11 sda released", sda_drv_low, 0);
    check("R11 busy", bus_busy, 0);
    check("R11 flags", {arb_lost, tx_error, xfer_done, rx_push}, 0);
  endtask

  task automatic t_write();
    int l0 = nlog, d0 = n_done, f0 = n_free;
    push(10'h1A0); push(10'h03C); push(10'h2C5);
    wait (bus_busy === 1'b1);
    @(negedge clk);
    check("R10 busy after start", bus_busy, 1);
    wait_idle();
    check("R3 byte count", nlog - l0, 3);
    check("R2 address byte", slog[l0 % 16], 8'hA0);
    check("R3 data byte 1", slog[(l0+1) % 16], 8'h3C);
    check("R3 data byte 2", slog[(l0+2) % 16], 8'hC5);
    check("R4 done pulse", n_done - d0, 1);
    check("R10 free event", n_free - f0, 1);
    check("R1 queue drained", wp - rp, 0);
    check("R9 scl high time", last_high, 2*TICK_DIV);
    check("R7 no error", tx_error, 0);
  endtask

  task automatic t_addr_only();
    int l0 = nlog, d0 = n_done;
    push(10'h3A0);
    wait_idle();
    check("R5 one byte", nlog - l0, 1);
    check("R5 address", slog[l0 % 16], 8'hA0);
    check("R5 done", n_done - d0, 1);
  endtask

  task automatic t_read();
    int r0 = n_rx, m0 = nmack, d0 = n_done;
    push(10'h1A1); push(10'h203);
    wait_idle();
    check("R6 rx count", n_rx - r0, 3);
    check("R6 rx byte 0", rxq[r0 % 16], 8'h5A);
    check("R6 rx byte 1", rxq[(r0+1) % 16], 8'hF0);
    check("R6 rx byte 2", rxq[(r0+2) % 16], 8'h81);
    check("R6 master acks", {mack[m0 % 16], mack[(m0+1) % 16], mack[(m0+2) % 16]}, 3'b001);
    check("R6 done", n_done - d0, 1);
  endtask

  task automatic t_restart();
    int l0 = nlog, r0 = n_rx, f0 = n_free;
    push(10'h1A0); push(10'h001); push(10'h1A1); push(10'h201);
    wait_idle();
    check("R2 bytes on bus", nlog - l0, 3);
    check("R2 second address", slog[(l0+2) % 16], 8'hA1);
    check("R2 single free event", n_free - f0, 1);
    check("R6 restart read byte", rxq[r0 % 16], 8'h5A);
    check("R6 restart read count", n_rx - r0, 1);
  endtask

  task automatic t_nack();
    int l0 = nlog, d0 = n_done;
    ack_en = 1'b0;
    push(10'h142); push(10'h011); push(10'h222);
    wait_idle();
    ack_en = 1'b1;
    check("R7 error set", tx_error, 1);
    check("R7 no done", n_done - d0, 0);
    check("R7 only address sent", nlog - l0, 1);
    check("R7 queue flushed", wp - rp, 0);
    check("R7 lines released", {scl_drv_low, sda_drv_low}, 0);
  endtask

  task automatic t_arb();
    int f0 = n_free;
    push(10'h1A0); push(10'h011); push(10'h222);
    wait (bus_busy === 1'b1);
    ext_low = 1'b1;
    wait (arb_lost === 1'b1);
    @(negedge clk);
    check("R8 arb flag", arb_lost, 1);
    check("R8 lines released", {scl_drv_low, sda_drv_low}, 0);
    ext_low = 1'b0;
    repeat (40) @(posedge clk);
    @(negedge clk);
    check("R8 queue flushed", wp - rp, 0);
    check("R10 free after release", n_free - f0, 1);
    check("R10 not busy", bus_busy, 0);
  endtask

  task automatic t_clear();
    int d0 = n_done;
    push(10'h3A0);
    wait_idle();
    check("R8 arb cleared", arb_lost, 0);
    check("R7 error cleared", tx_error, 0);
    check("R4 done after clear", n_done - d0, 1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc >= WDOG_LIMIT) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WDOG_LIMIT);
      finish_run();
    end
  end

  initial begin
    txdat[0] = 8'h5A; txdat[1] = 8'hF0; txdat[2] = 8'h81; txdat[3] = 8'h3C;
    repeat (5) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_write();
    t_addr_only();
    t_read();
    t_restart();
    t_nack();
    t_arb();
    t_clear();
    finish_run();
  end

endmodule